// File: doc/BRIEF.md
# Dual-Port Signal Register with Constant Readback

This block holds one 16-bit register location that two hosts share: a local processor port and a backplane port. The location behaves differently for reads and writes. A read never touches stored data; it always returns a fixed 16-bit capability word, 16'h1FFF. A write drops the written word into a two-entry signal queue. When the queue is already full, the write is refused. The refusal is reported as a bus error in the same cycle, and the word is not silently lost.

Local software drains the queue through a valid/ready output stream. `sig_valid` doubles as the "signal pending" status. `sig_data` presents the oldest word. A cycle with both `sig_valid` and `sig_ready` high consumes that word. When `sig_valid` is low, `sig_ready` has no effect. An interrupt request follows the pending status whenever the local enable input is set.

Each host request is a valid/ready transfer, and the block never buffers a request. A request that hits the register and cannot complete in this cycle is back-pressured. This happens only to a local write that collides with a backplane write, and it must be held until `lcl_ready` is high. A write that meets a full queue still completes its handshake (ready high), but with `*_berr` set.

Top module: `sigreg_port`

## Requirements
- R1: A request with valid high and write low that hits the register returns 16'h1FFF on that port's rdata, with ready high in the same cycle. The queue is unchanged. The upper byte 8'h1F lies in rdata[15:8] and the lower byte 8'hFF lies in rdata[7:0].
- R2: A request hits when addr[15:1] equals 15'h40A4, so byte addresses 16'h8148 and 16'h8149 both hit and addr[0] is ignored. A request at any other address gets ready low and berr low, rdata 16'h0000, and no queue change.
- R3: An accepted write stores its wdata. Stored words leave `sig_data` in the order they were accepted, and `sig_data` always shows the oldest word.
- R4: The queue holds exactly two words. Two accepted writes in a row on an empty queue are both kept.
- R5: A write that hits while two words are stored and no pop happens in that cycle is not stored. That port's berr is high in the same cycle, with ready high.
- R6: `sig_valid` is 0 when the queue is empty and 1 otherwise. It changes in the cycle after the edge that changes the fill level.
- R7: A cycle with `sig_valid` and `sig_ready` both high removes the oldest word. `sig_ready` on an empty queue changes nothing.
- R8: A pop and a write in the same cycle on a full queue accept the write without berr. The queue stays full, and the write lands behind the remaining word.
- R9: `irq` is high exactly when `sig_valid` and `irq_en` are both high.
- R10: When both ports write the register in one cycle, the backplane write is served. `lcl_ready` is low, `lcl_berr` is low and the local word is not stored. A local read in that cycle still completes.
- R11: After reset the queue is empty, and `sig_valid`, `irq` and both berr outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lcl_valid | input | 1 | Local request valid |
| lcl_write | input | 1 | Local request is a write |
| lcl_addr | input | 16 | Local byte address |
| lcl_wdata | input | 16 | Local write word |
| lcl_ready | output | 1 | Local request completes this cycle |
| lcl_rdata | output | 16 | Local read word |
| lcl_berr | output | 1 | Local write refused, queue full |
| bp_valid | input | 1 | Backplane request valid |
| bp_write | input | 1 | Backplane request is a write |
| bp_addr | input | 16 | Backplane byte address |
| bp_wdata | input | 16 | Backplane write word |
| bp_ready | output | 1 | Backplane request completes this cycle |
| bp_rdata | output | 16 | Backplane read word |
| bp_berr | output | 1 | Backplane write refused, queue full |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt request |
| sig_valid | output | 1 | Queue non-empty (signal pending) |
| sig_data | output | 16 | Oldest queued word |
| sig_ready | input | 1 | Pop strobe for the oldest word |

## Verification
The assertions check several properties on every cycle. Fill never exceeds two. A refused write leaves the fill level alone. A swap on a full queue keeps it full, and a pop on an empty queue is inert. A hitting read always returns the constant. A collision always stalls the local port, and an address miss never handshakes. Stored contents and their order can only be shown by the bench's scenarios. The bench sweeps every fill level against every pairing of port operations and pop strobe, then drains the queue word by word. Berr timing at each fill level, irq with the enable in both states, and reset from a full queue also come from those scenarios.

// File: rtl/sigreg_pkg.sv
package sigreg_pkg;
  parameter int unsigned DATA_W     = 16;
  parameter int unsigned ADDR_W     = 16;
  parameter int unsigned QUEUE_DEPTH = 2;
  parameter logic [DATA_W-1:0] CAP_WORD = 16'h1FFF;
  parameter logic [ADDR_W-1:0] REG_BYTE_ADDR = 16'h8148;

  localparam int unsigned PORT_BP  = 0;
  localparam int unsigned PORT_LCL = 1;
  localparam int unsigned N_PORTS  = 2;

  typedef struct packed {
    logic rd;
    logic wr;
  } hit_t;
endpackage

// File: rtl/sigreg_hostdec.sv
module sigreg_hostdec
  import sigreg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] MATCH = REG_BYTE_ADDR
) (
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  output hit_t          hit
);
  logic unused_lane;
  logic match;

  assign unused_lane = addr[0];
  assign match  = (addr[AW-1:1] == MATCH[AW-1:1]);
  assign hit.rd = valid & ~write & match;
  assign hit.wr = valid &  write & match;
endmodule

// File: rtl/sigreg_arb.sv
module sigreg_arb
  import sigreg_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  hit_t          bp_hit,
  input  hit_t          lcl_hit,
  input  logic [DW-1:0] bp_wdata,
  input  logic [DW-1:0] lcl_wdata,
  input  logic          room,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          bp_berr,
  output logic          lcl_berr,
  output logic          lcl_stall
);
  logic lcl_wins;

  assign lcl_stall = lcl_hit.wr & bp_hit.wr;
  assign lcl_wins  = lcl_hit.wr & ~bp_hit.wr;
  assign push      = bp_hit.wr | lcl_wins;
  assign push_data = bp_hit.wr ? bp_wdata : lcl_wdata;
  assign bp_berr   = bp_hit.wr & ~room;
  assign lcl_berr  = lcl_wins & ~room;
endmodule

// File: rtl/sigreg_fifo.sv
module sigreg_fifo
  import sigreg_pkg::*;
#(
  parameter int unsigned DEPTH = QUEUE_DEPTH,
  parameter int unsigned DW    = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          room,
  output logic          nonempty,
  output logic [DW-1:0] head
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic [CW-1:0] wr_idx;
  logic [DW-1:0] mem_q [DEPTH];
  logic          pop_eff;
  logic          push_eff;

  assign pop_eff  = pop & (count_q != '0);
  assign room     = (count_q != FULL_CNT) | pop_eff;
  assign push_eff = push & room;
  assign wr_idx   = count_q - CW'(pop_eff);
  assign count_d  = count_q + CW'(push_eff) - CW'(pop_eff);
  assign nonempty = (count_q != '0);
  assign head     = mem_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] above;
    logic [DW-1:0] slot_d;
    if (i + 1 < DEPTH) begin : g_mid
      assign above = mem_q[i+1];
    end else begin : g_top
      assign above = '0;
    end
    always_comb begin
      slot_d = pop_eff ? above : mem_q[i];
      if (push_eff && wr_idx == CW'(i)) slot_d = push_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= slot_d;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

  assert_refused_keeps_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count_q == FULL_CNT && !pop) |=> (count_q == FULL_CNT));

  assert_swap_stays_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && count_q == FULL_CNT) |=> (count_q == FULL_CNT));

  assert_empty_pop_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count_q == '0) |=> (count_q == '0));
endmodule

// File: rtl/sigreg_port.sv
module sigreg_port
  import sigreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_valid,
  input  logic              lcl_write,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic [DATA_W-1:0] lcl_wdata,
  output logic              lcl_ready,
  output logic [DATA_W-1:0] lcl_rdata,
  output logic              lcl_berr,
  input  logic              bp_valid,
  input  logic              bp_write,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [DATA_W-1:0] bp_wdata,
  output logic              bp_ready,
  output logic [DATA_W-1:0] bp_rdata,
  output logic              bp_berr,
  input  logic              irq_en,
  output logic              irq,
  output logic              sig_valid,
  output logic [DATA_W-1:0] sig_data,
  input  logic              sig_ready
);
  logic [N_PORTS-1:0]             p_valid;
  logic [N_PORTS-1:0]             p_write;
  logic [N_PORTS-1:0][ADDR_W-1:0] p_addr;
  hit_t                           p_hit [N_PORTS];
  logic                           push;
  logic [DATA_W-1:0]              push_data;
  logic                           room;
  logic                           lcl_stall;

  assign p_valid[PORT_BP]  = bp_valid;
  assign p_write[PORT_BP]  = bp_write;
  assign p_addr[PORT_BP]   = bp_addr;
  assign p_valid[PORT_LCL] = lcl_valid;
  assign p_write[PORT_LCL] = lcl_write;
  assign p_addr[PORT_LCL]  = lcl_addr;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_dec
    sigreg_hostdec #(.AW(ADDR_W), .MATCH(REG_BYTE_ADDR)) u_dec (
      .valid (p_valid[p]),
      .write (p_write[p]),
      .addr  (p_addr[p]),
      .hit   (p_hit[p])
    );
  end

  sigreg_arb #(.DW(DATA_W)) u_arb (
    .bp_hit    (p_hit[PORT_BP]),
    .lcl_hit   (p_hit[PORT_LCL]),
    .bp_wdata  (bp_wdata),
    .lcl_wdata (lcl_wdata),
    .room      (room),
    .push      (push),
    .push_data (push_data),
    .bp_berr   (bp_berr),
    .lcl_berr  (lcl_berr),
    .lcl_stall (lcl_stall)
  );

  sigreg_fifo #(.DEPTH(QUEUE_DEPTH), .DW(DATA_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (sig_ready),
    .room      (room),
    .nonempty  (sig_valid),
    .head      (sig_data)
  );

  assign bp_ready  = p_hit[PORT_BP].rd | p_hit[PORT_BP].wr;
  assign lcl_ready = p_hit[PORT_LCL].rd | (p_hit[PORT_LCL].wr & ~lcl_stall);
  assign bp_rdata  = p_hit[PORT_BP].rd  ? CAP_WORD : '0;
  assign lcl_rdata = p_hit[PORT_LCL].rd ? CAP_WORD : '0;
  assign irq       = sig_valid & irq_en;

  assert_const_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_valid && !bp_write && bp_addr[ADDR_W-1:1] == REG_BYTE_ADDR[ADDR_W-1:1])
      |-> (bp_ready && bp_rdata == 16'h1FFF));

  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_addr[ADDR_W-1:1] != REG_BYTE_ADDR[ADDR_W-1:1]) |-> (!lcl_ready && !lcl_berr));

  assert_bp_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_valid && bp_write && bp_ready && lcl_valid && lcl_write)
      |-> (!lcl_ready && !lcl_berr));

  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sig_valid);
endmodule

// File: tb/sigreg_port_bench.sv
module sigreg_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lcl_valid = 0, lcl_write = 0, bp_valid = 0, bp_write = 0;
  logic [15:0] lcl_addr = '0, lcl_wdata = '0, bp_addr = '0, bp_wdata = '0;
  logic lcl_ready, lcl_berr, bp_ready, bp_berr, irq, sig_valid;
  logic [15:0] lcl_rdata, bp_rdata, sig_data;
  logic irq_en = 0, sig_ready = 0;

  int errors = 0;
  int checks = 0;
  int mq [4];
  int mn = 0;
  int tagc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sigreg_port u_sigreg_port (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_write(lcl_write), .lcl_addr(lcl_addr),
    .lcl_wdata(lcl_wdata), .lcl_ready(lcl_ready), .lcl_rdata(lcl_rdata),
    .lcl_berr(lcl_berr),
    .bp_valid(bp_valid), .bp_write(bp_write), .bp_addr(bp_addr),
    .bp_wdata(bp_wdata), .bp_ready(bp_ready), .bp_rdata(bp_rdata),
    .bp_berr(bp_berr),
    .irq_en(irq_en), .irq(irq),
    .sig_valid(sig_valid), .sig_data(sig_data), .sig_ready(sig_ready)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // op: 0 idle, 1 read hit, 2 write hit, 3 write at another address
  function automatic logic [15:0] op_addr(input int op, input logic [15:0] d);
    if (op == 3) return 16'h814C;
    return d[0] ? 16'h8149 : 16'h8148;
  endfunction

  task automatic idle_all();
    bp_valid = 0; bp_write = 0; lcl_valid = 0; lcl_write = 0; sig_ready = 0;
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      idle_all();
      bp_valid = 1; bp_write = 1;
      bp_wdata = 16'hC000 + 16'(tagc); bp_addr = op_addr(2, bp_wdata);
      mq[mn] = 32'(bp_wdata); mn++; tagc++;
      @(posedge clk);
    end
    @(negedge clk);
    idle_all();
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle_all();
      sig_ready = 1;
      #2;
      chk("R6", "drain sig_valid", 32'(sig_valid), 32'(mn > 0));
      if (mn > 0) begin
        chk("R3", "drain order", 32'(sig_data), 32'(mq[0]));
        for (int j = 0; j < 3; j++) mq[j] = mq[j+1];
        mn--;
      end
      @(posedge clk);
    end
    @(negedge clk);
    idle_all();
    #2;
    chk("R7", "empty after drain", 32'(sig_valid), 32'd0);
  endtask

  task automatic combo(input int bop, input int lop, input bit pop, input bit ien);
    int room;
    bit bwr, lwr, pe;
    @(negedge clk);
    bp_wdata  = 16'hB000 + 16'(tagc);
    lcl_wdata = 16'hA000 + 16'(tagc);
    tagc++;
    bp_valid  = (bop != 0); bp_write  = (bop >= 2); bp_addr  = op_addr(bop, bp_wdata);
    lcl_valid = (lop != 0); lcl_write = (lop >= 2); lcl_addr = op_addr(lop, lcl_wdata);
    sig_ready = pop; irq_en = ien;
    #2;
    pe   = pop && (mn > 0);
    room = 2 - mn + (pe ? 1 : 0);
    bwr  = (bop == 2);
    lwr  = (lop == 2) && !bwr;
    chk(bop == 3 ? "R2" : "R1", "bp_ready", 32'(bp_ready), 32'(bop == 1 || bop == 2));
    chk(bop == 3 ? "R2" : "R1", "bp_rdata", 32'(bp_rdata), bop == 1 ? 32'h1FFF : 32'h0);
    chk(lop == 3 ? "R2" : "R10", "lcl_ready", 32'(lcl_ready),
        32'(lop == 1 || (lop == 2 && !bwr)));
    chk(lop == 3 ? "R2" : "R1", "lcl_rdata", 32'(lcl_rdata), lop == 1 ? 32'h1FFF : 32'h0);
    chk(pe && mn == 2 ? "R8" : "R5", "bp_berr", 32'(bp_berr), 32'(bwr && room == 0));
    chk(bwr && lop == 2 ? "R10" : "R5", "lcl_berr", 32'(lcl_berr), 32'(lwr && room == 0));
    chk("R9", "irq", 32'(irq), 32'((mn > 0) && ien));
    chk("R6", "sig_valid", 32'(sig_valid), 32'(mn > 0));
    if (mn > 0) chk("R3", "head", 32'(sig_data), 32'(mq[0]));
    if (pe) begin
      for (int j = 0; j < 3; j++) mq[j] = mq[j+1];
      mn--;
    end
    if ((bwr || lwr) && room > 0) begin
      mq[mn] = bwr ? 32'(bp_wdata) : 32'(lcl_wdata);
      mn++;
    end
    @(posedge clk);
    @(negedge clk);
    idle_all();
    #2;
    chk("R4", "level after op", 32'(sig_valid), 32'(mn > 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    irq_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset sig_valid", 32'(sig_valid), 32'd0);
    chk("R11", "reset irq", 32'(irq), 32'd0);
    chk("R11", "reset bp_berr", 32'(bp_berr), 32'd0);
    chk("R11", "reset lcl_berr", 32'(lcl_berr), 32'd0);
    rst_n = 1;

    for (int f = 0; f < 3; f++)
      for (int b = 0; b < 4; b++)
        for (int l = 0; l < 4; l++)
          for (int p = 0; p < 2; p++) begin
            fill(f);
            combo(b, l, p[0], (b + l + f) % 2 == 0);
            drain();
          end

    // R4 / R5: two back-to-back writes kept, third refused
    fill(2);
    combo(2, 0, 0, 1);
    drain();

    // R11: reset from a full queue
    fill(2);
    @(negedge clk);
    irq_en = 1;
    rst_n = 0;
    #2;
    chk("R11", "mid reset sig_valid", 32'(sig_valid), 32'd0);
    chk("R11", "mid reset irq", 32'(irq), 32'd0);
    mn = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "post reset sig_valid", 32'(sig_valid), 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule